// File: doc/BRIEF.md
# Serial debug command responder

This block is the command engine behind a serial debug port that is used while the processor core is halted. The host runs full-duplex transfers: each transfer carries one 16-bit command or operand word into the block and, at the same time, carries out one response word made of a status bit and 16 data bits. The response that a transfer produces is the word shifted out during the following transfer. Bit-level shifting is outside this block. Each transfer appears here as a one-cycle `xfer_valid` strobe with the received word. The pending outgoing word is always visible on `resp_status`/`resp_data`.

Three commands are decoded. NOP does nothing. Register read samples an asynchronous register-file read port and returns 32 bits as two words. Memory read collects a 32-bit address over two operand transfers, then runs a request/acknowledge access on the memory port and returns a byte, word or long result. The last result word is shifted out during the transfer that delivers the next command. Transfers that arrive while an access is outstanding receive a not-ready reply, and their contents are dropped.

Command encoding: bits [15:12] hold the opcode. 0 is NOP, 1 is memory read and 2 is register read; the other values are unassigned. For memory read, bits [1:0] give the size: 00 byte, 01 word, 10 long, 11 unassigned. For register read, bits [3:0] select the register, and bit 3 set means an address register. All other bits of a command are reserved and must be zero.

Top module: `dbg_cmd_responder`

## Requirements
- R1: After reset the pending response is not-ready (status 1, data 0x0000), the sequencer waits for a command and `mem_req` is low.
- R2: A NOP command (word 0x0000) makes the next response command-complete (status 0, data 0xFFFF).
- R3: An unassigned opcode, a memory read with size 11, or any command with a nonzero reserved bit makes the next response illegal-command (status 1, data 0xFFFF). No access starts.
- R4: A register read with `core_halted` high drives `reg_sel` from bits [3:0] and returns `reg_rdata[31:16]`, then `reg_rdata[15:0]`, both with status 0. The operand of the transfer that carries the upper half is ignored.
- R5: A register read with `core_halted` low makes the next response bus-error (status 1, data 0x0001) and returns the sequencer to waiting for a command.
- R6: A memory read answers not-ready to the command transfer and to the next transfer (upper address bits). The third transfer (lower address bits) starts the access, with `mem_addr` = {upper, lower} and `mem_size` = command bits [1:0].
- R7: While `mem_req` is high, it stays high with `mem_addr` stable until `mem_ack`. Every response in that time is not-ready, and the words received are ignored.
- R8: A long memory read returns the upper result half in the first transfer after the access completes and the lower half in the second. The word received in that second transfer is decoded as the next command.
- R9: A word memory read returns `mem_rdata[15:0]` in one response word. A byte read returns `mem_rdata[7:0]` in the low 8 bits with the upper 8 bits zero. The word received with that result is the next command.
- R10: An access acknowledged with `mem_err` high returns the single response bus-error (status 1, data 0x0001) in place of result data. The word received with it is the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | One-cycle strobe marking a completed transfer |
| xfer_word | input | 16 | Word received in the transfer |
| resp_status | output | 1 | Status bit of the pending response word |
| resp_data | output | 16 | Data field of the pending response word |
| core_halted | input | 1 | High while the core is halted |
| reg_sel | output | 4 | Register select for the asynchronous register-file read |
| reg_rdata | input | 32 | Register-file read data |
| mem_req | output | 1 | Memory read request, held until acknowledge |
| mem_addr | output | 32 | Memory read address |
| mem_size | output | 2 | Access size: 00 byte, 01 word, 10 long |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_err | input | 1 | Bus error, sampled with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, sampled with `mem_ack` |

## Verification
The properties assume that `xfer_valid` is a single-cycle strobe, that `mem_ack` rises only while `mem_req` is high and lasts one cycle, and that `mem_err` and `mem_rdata` are meaningful only in the acknowledge cycle. The bench drives transfers on falling edges, each as a one-cycle pulse followed by idle cycles. Its memory model acknowledges a fixed number of cycles after it sees a request and then drops the acknowledge at once. Transfers sent during an outstanding access are placed well before that acknowledge, so polling and completion never meet in the same cycle.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_NOP   = 4'h0;
  localparam logic [OPC_W-1:0] OPC_MEMRD = 4'h1;
  localparam logic [OPC_W-1:0] OPC_REGRD = 4'h2;

  typedef enum logic [1:0] {
    K_NOP     = 2'd0,
    K_MEMRD   = 2'd1,
    K_REGRD   = 2'd2,
    K_ILLEGAL = 2'd3
  } cmd_kind_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } xfer_size_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ADDR_HI  = 3'd1,
    ST_ADDR_LO  = 3'd2,
    ST_MEM_WAIT = 3'd3,
    ST_RES_LO   = 3'd4
  } seq_state_t;

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
  import dbg_cmd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic [WORD_W-1:0] word_i,
  output cmd_kind_t         kind_o,
  output xfer_size_t        size_o,
  output logic [SEL_W-1:0]  sel_o
);

  localparam int BODY_W = WORD_W - OPC_W;

  logic [OPC_W-1:0]  opc;
  logic [BODY_W-1:0] body;
  logic              mem_rsvd_clear;
  logic              reg_rsvd_clear;

  assign opc  = word_i[WORD_W-1 -: OPC_W];
  assign body = word_i[BODY_W-1:0];

  assign mem_rsvd_clear = (body[BODY_W-1:2] == '0);
  assign reg_rsvd_clear = (body[BODY_W-1:SEL_W] == '0);

  assign size_o = xfer_size_t'(word_i[1:0]);
  assign sel_o  = word_i[SEL_W-1:0];

  always_comb begin
    kind_o = K_ILLEGAL;
    unique case (opc)
      OPC_NOP:   if (body == '0) kind_o = K_NOP;
      OPC_MEMRD: if (mem_rsvd_clear && (size_o != SZ_BAD)) kind_o = K_MEMRD;
      OPC_REGRD: if (reg_rsvd_clear) kind_o = K_REGRD;
      default:   kind_o = K_ILLEGAL;
    endcase
  end

endmodule

// File: rtl/dbg_mem_master.sv
module dbg_mem_master
  import dbg_cmd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                size_load_i,
  input  xfer_size_t          size_i,
  input  logic                hi_load_i,
  input  logic                lo_load_start_i,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                mem_ack_i,
  output logic                mem_req_o,
  output logic [2*WORD_W-1:0] mem_addr_o,
  output logic [1:0]          mem_size_o
);

  logic [WORD_W-1:0] addr_hi_q, addr_hi_d;
  logic [WORD_W-1:0] addr_lo_q, addr_lo_d;
  xfer_size_t        size_q, size_d;
  logic              req_q, req_d;

  always_comb begin
    addr_hi_d = addr_hi_q;
    addr_lo_d = addr_lo_q;
    size_d    = size_q;
    req_d     = req_q;
    if (size_load_i)     size_d    = size_i;
    if (hi_load_i)       addr_hi_d = word_i;
    if (lo_load_start_i) begin
      addr_lo_d = word_i;
      req_d     = 1'b1;
    end else if (req_q && mem_ack_i) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      size_q    <= SZ_BYTE;
      req_q     <= 1'b0;
    end else begin
      if (size_load_i)     size_q    <= size_d;
      if (hi_load_i)       addr_hi_q <= addr_hi_d;
      if (lo_load_start_i) addr_lo_q <= addr_lo_d;
      req_q <= req_d;
    end
  end

  assign mem_req_o  = req_q;
  assign mem_addr_o = {addr_hi_q, addr_lo_q};
  assign mem_size_o = size_q;

endmodule

// File: rtl/dbg_result_fmt.sv
module dbg_result_fmt
  import dbg_cmd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [2*WORD_W-1:0] rdata_i,
  input  xfer_size_t          size_i,
  input  logic                err_i,
  output logic [WORD_W:0]     first_o,
  output logic [WORD_W-1:0]   second_o,
  output logic                two_words_o
);

  localparam int BYTE_W = WORD_W / 2;
  localparam logic [WORD_W:0] RESP_BUS_ERR = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};

  always_comb begin
    second_o    = rdata_i[WORD_W-1:0];
    two_words_o = 1'b0;
    if (err_i) begin
      first_o = RESP_BUS_ERR;
    end else begin
      unique case (size_i)
        SZ_BYTE: first_o = {1'b0, {(WORD_W-BYTE_W){1'b0}}, rdata_i[BYTE_W-1:0]};
        SZ_WORD: first_o = {1'b0, rdata_i[WORD_W-1:0]};
        default: begin
          first_o     = {1'b0, rdata_i[2*WORD_W-1:WORD_W]};
          two_words_o = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/dbg_cmd_responder.sv
module dbg_cmd_responder
  import dbg_cmd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SEL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_valid,
  input  logic [WORD_W-1:0]   xfer_word,
  output logic                resp_status,
  output logic [WORD_W-1:0]   resp_data,
  input  logic                core_halted,
  output logic [SEL_W-1:0]    reg_sel,
  input  logic [2*WORD_W-1:0] reg_rdata,
  output logic                mem_req,
  output logic [2*WORD_W-1:0] mem_addr,
  output logic [1:0]          mem_size,
  input  logic                mem_ack,
  input  logic                mem_err,
  input  logic [2*WORD_W-1:0] mem_rdata
);

  localparam int LONG_W = 2 * WORD_W;
  localparam logic [WORD_W:0] RESP_NOT_READY = {1'b1, {WORD_W{1'b0}}};
  localparam logic [WORD_W:0] RESP_ILLEGAL   = {1'b1, {WORD_W{1'b1}}};
  localparam logic [WORD_W:0] RESP_DONE      = {1'b0, {WORD_W{1'b1}}};
  localparam logic [WORD_W:0] RESP_BUS_ERR   = {1'b1, {(WORD_W-1){1'b0}}, 1'b1};

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cmd_kind_t  dec_kind;
  xfer_size_t dec_size;

  dbg_cmd_decode #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_decode (
    .word_i (xfer_word),
    .kind_o (dec_kind),
    .size_o (dec_size),
    .sel_o  (reg_sel)
  );

  logic size_load, hi_load, lo_load_start;

  dbg_mem_master #(.WORD_W(WORD_W)) u_mem (
    .clk             (clk),
    .rst_n           (rst_sync_n),
    .size_load_i     (size_load),
    .size_i          (dec_size),
    .hi_load_i       (hi_load),
    .lo_load_start_i (lo_load_start),
    .word_i          (xfer_word),
    .mem_ack_i       (mem_ack),
    .mem_req_o       (mem_req),
    .mem_addr_o      (mem_addr),
    .mem_size_o      (mem_size)
  );

  logic [WORD_W:0]   fmt_first;
  logic [WORD_W-1:0] fmt_second;
  logic              fmt_two;

  dbg_result_fmt #(.WORD_W(WORD_W)) u_fmt (
    .rdata_i     (mem_rdata),
    .size_i      (xfer_size_t'(mem_size)),
    .err_i       (mem_err),
    .first_o     (fmt_first),
    .second_o    (fmt_second),
    .two_words_o (fmt_two)
  );

  seq_state_t        state_q, state_d;
  logic [WORD_W:0]   resp_q, resp_d;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              resp_en, hold_en;

  always_comb begin
    state_d       = state_q;
    resp_d        = resp_q;
    hold_d        = hold_q;
    size_load     = 1'b0;
    hi_load       = 1'b0;
    lo_load_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (xfer_valid) begin
          unique case (dec_kind)
            K_NOP:   resp_d = RESP_DONE;
            K_MEMRD: begin
              size_load = 1'b1;
              resp_d    = RESP_NOT_READY;
              state_d   = ST_ADDR_HI;
            end
            K_REGRD: begin
              if (core_halted) begin
                resp_d  = {1'b0, reg_rdata[LONG_W-1:WORD_W]};
                hold_d  = reg_rdata[WORD_W-1:0];
                state_d = ST_RES_LO;
              end else begin
                resp_d  = RESP_BUS_ERR;
              end
            end
            default: resp_d = RESP_ILLEGAL;
          endcase
        end
      end
      ST_ADDR_HI: begin
        if (xfer_valid) begin
          hi_load = 1'b1;
          resp_d  = RESP_NOT_READY;
          state_d = ST_ADDR_LO;
        end
      end
      ST_ADDR_LO: begin
        if (xfer_valid) begin
          lo_load_start = 1'b1;
          resp_d        = RESP_NOT_READY;
          state_d       = ST_MEM_WAIT;
        end
      end
      ST_MEM_WAIT: begin
        if (mem_ack) begin
          resp_d  = fmt_first;
          hold_d  = fmt_second;
          state_d = fmt_two ? ST_RES_LO : ST_IDLE;
        end
      end
      ST_RES_LO: begin
        if (xfer_valid) begin
          resp_d  = {1'b0, hold_q};
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign resp_en = xfer_valid || (state_q == ST_MEM_WAIT && mem_ack);
  assign hold_en = (state_d == ST_RES_LO) && (state_q != ST_RES_LO);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      resp_q  <= RESP_NOT_READY;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      if (resp_en) resp_q <= resp_d;
      if (hold_en) hold_q <= hold_d;
    end
  end

  assign resp_status = resp_q[WORD_W];
  assign resp_data   = resp_q[WORD_W-1:0];

endmodule

// File: rtl/dbg_cmd_responder_chk.sv
module dbg_cmd_responder_chk
  import dbg_cmd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                xfer_valid,
  input logic [WORD_W-1:0]   xfer_word,
  input logic                resp_status,
  input logic [WORD_W-1:0]   resp_data,
  input logic                core_halted,
  input logic                mem_req,
  input logic [2*WORD_W-1:0] mem_addr,
  input logic                mem_ack,
  input logic                mem_err,
  input seq_state_t          state_q
);

  logic [OPC_W-1:0] opc;
  logic             at_idle;
  assign opc     = xfer_word[WORD_W-1 -: OPC_W];
  assign at_idle = (state_q == ST_IDLE);

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (resp_status && resp_data == '0 && !mem_req));

  a_r3_unassigned_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && at_idle && opc > OPC_REGRD) |=>
      (resp_status && resp_data == {WORD_W{1'b1}} && !mem_req));

  a_r5_running_reg_read: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && at_idle && xfer_word == {OPC_REGRD, {(WORD_W-OPC_W){1'b0}}} && !core_halted) |=>
      (resp_status && resp_data == {{(WORD_W-1){1'b0}}, 1'b1}));

  a_r6_access_start: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && state_q == ST_ADDR_LO) |=>
      (mem_req && mem_addr[WORD_W-1:0] == $past(xfer_word)));

  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r7_not_ready_pending: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (resp_status && resp_data == '0));

  a_r10_bus_error: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=>
      (resp_status && resp_data == {{(WORD_W-1){1'b0}}, 1'b1} && !mem_req));

endmodule

bind dbg_cmd_responder dbg_cmd_responder_chk #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_valid  (xfer_valid),
  .xfer_word   (xfer_word),
  .resp_status (resp_status),
  .resp_data   (resp_data),
  .core_halted (core_halted),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_ack     (mem_ack),
  .mem_err     (mem_err),
  .state_q     (state_q)
);

// File: tb/dbg_cmd_responder_tb.sv
module dbg_cmd_responder_tb;

  localparam int W = 16;
  localparam logic [16:0] NR   = 17'h10000;
  localparam logic [16:0] ILL  = 17'h1FFFF;
  localparam logic [16:0] DONE = 17'h0FFFF;
  localparam logic [16:0] BERR = 17'h10001;
  localparam int LAT = 6;
  localparam logic [31:0] ERR_ADDR = 32'hDEAD_0BAD;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          xfer_valid;
  logic [W-1:0]  xfer_word;
  logic          resp_status;
  logic [W-1:0]  resp_data;
  logic          core_halted;
  logic [3:0]    reg_sel;
  logic [31:0]   reg_rdata;
  logic          mem_req;
  logic [31:0]   mem_addr;
  logic [1:0]    mem_size;
  logic          mem_ack;
  logic          mem_err;
  logic [31:0]   mem_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int lat_cnt  = 0;
  logic [31:0] seen_addr;
  logic [1:0]  seen_size;

  always #10 clk = ~clk;

  dbg_cmd_responder u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_word(xfer_word),
    .resp_status(resp_status), .resp_data(resp_data), .core_halted(core_halted),
    .reg_sel(reg_sel), .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] regf(input logic [3:0] s);
    return {12'hA5C, s, 12'h3E1, s};
  endfunction

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  assign reg_rdata = regf(reg_sel);

  // memory model: acknowledges LAT falling edges after a request is seen
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0; lat_cnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; mem_err = 1'b0; lat_cnt = 0;
    end else if (mem_req) begin
      if (lat_cnt == 0) begin
        seen_addr = mem_addr;
        seen_size = mem_size;
      end
      if (lat_cnt == LAT) begin
        mem_ack   = 1'b1;
        mem_err   = (mem_addr == ERR_ADDR);
        mem_rdata = memf(mem_addr);
      end
      lat_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [W-1:0] w, output logic [16:0] got);
    @(negedge clk);
    got = {resp_status, resp_data};
    xfer_word  = w;
    xfer_valid = 1'b1;
    @(negedge clk);
    xfer_valid = 1'b0;
    xfer_word  = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [16:0] g;
    @(negedge clk);
    g = {resp_status, resp_data};
    chk("R1 response after reset", {15'd0, g}, {15'd0, NR});
    chk("R1 request after reset", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_nop();
    logic [16:0] g;
    xfer(16'h0000, g);
    xfer(16'h0000, g);
    chk("R2 nop complete", {15'd0, g}, {15'd0, DONE});
  endtask

  task automatic t_illegal();
    logic [16:0] g;
    xfer(16'h7000, g);
    xfer(16'h0010, g);
    chk("R3 unassigned opcode", {15'd0, g}, {15'd0, ILL});
    xfer(16'h1003, g);
    chk("R3 nop reserved bit", {15'd0, g}, {15'd0, ILL});
    xfer(16'h2010, g);
    chk("R3 bad memory size", {15'd0, g}, {15'd0, ILL});
    chk("R3 no access started", {31'd0, mem_req}, 32'd0);
    xfer(16'h0000, g);
    chk("R3 reg read reserved bit", {15'd0, g}, {15'd0, ILL});
    xfer(16'h0000, g);
    chk("R3 back to idle", {15'd0, g}, {15'd0, DONE});
  endtask

  task automatic t_reg_halted(input logic [3:0] sel);
    logic [16:0] g;
    logic [31:0] v;
    v = regf(sel);
    core_halted = 1'b1;
    xfer({4'h2, 8'h00, sel}, g);
    xfer(16'hFFFF, g);
    chk("R4 upper half", {15'd0, g}, {15'd0, 1'b0, v[31:16]});
    xfer(16'h0000, g);
    chk("R4 lower half", {15'd0, g}, {15'd0, 1'b0, v[15:0]});
    xfer(16'h0000, g);
    chk("R4 next opcode decoded", {15'd0, g}, {15'd0, DONE});
  endtask

  task automatic t_reg_running();
    logic [16:0] g;
    core_halted = 1'b0;
    xfer(16'h2003, g);
    xfer(16'h0000, g);
    chk("R5 bus error while running", {15'd0, g}, {15'd0, BERR});
    xfer(16'h0000, g);
    chk("R5 returns to idle", {15'd0, g}, {15'd0, DONE});
    core_halted = 1'b1;
  endtask

  task automatic t_mem(input logic [1:0] size, input logic [31:0] addr);
    logic [16:0] g;
    logic [31:0] d;
    d = memf(addr);
    xfer({4'h1, 10'd0, size}, g);
    xfer(addr[31:16], g);
    chk("R6 not-ready on upper address", {15'd0, g}, {15'd0, NR});
    xfer(addr[15:0], g);
    chk("R6 not-ready on lower address", {15'd0, g}, {15'd0, NR});
    chk("R6 access address", seen_addr, addr);
    chk("R6 access size", {30'd0, seen_size}, {30'd0, size});
    chk("R7 request pending", {31'd0, mem_req}, 32'd1);
    xfer(16'h1002, g);
    chk("R7 not-ready while pending", {15'd0, g}, {15'd0, NR});
    while (mem_req) @(negedge clk);
    repeat (2) @(negedge clk);
    if (addr == ERR_ADDR) begin
      xfer(16'h0000, g);
      chk("R10 bus error result", {15'd0, g}, {15'd0, BERR});
      xfer(16'h0000, g);
      chk("R10 word with error was a command", {15'd0, g}, {15'd0, DONE});
    end else if (size == 2'b10) begin
      xfer(16'h0000, g);
      chk("R8 upper result word", {15'd0, g}, {15'd0, 1'b0, d[31:16]});
      xfer(16'h7000, g);
      chk("R8 lower result word", {15'd0, g}, {15'd0, 1'b0, d[15:0]});
      xfer(16'h0000, g);
      chk("R8 overlapped opcode decoded", {15'd0, g}, {15'd0, ILL});
    end else begin
      xfer(16'h0000, g);
      if (size == 2'b00)
        chk("R9 byte result", {15'd0, g}, {15'd0, 1'b0, 8'h00, d[7:0]});
      else
        chk("R9 word result", {15'd0, g}, {15'd0, 1'b0, d[15:0]});
      xfer(16'h0000, g);
      chk("R9 word with result was a command", {15'd0, g}, {15'd0, DONE});
    end
    chk("R7 polled word ignored", {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; xfer_valid = 1'b0; xfer_word = '0; core_halted = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_nop();
    t_illegal();
    t_reg_halted(4'h5);
    t_reg_halted(4'hB);
    t_reg_running();
    t_mem(2'b10, 32'h1234_5678);
    t_mem(2'b01, 32'h0040_8001);
    t_mem(2'b00, 32'h0000_00C3);
    t_mem(2'b10, ERR_ADDR);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule